// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the address stream for a single DMA channel. A channel is described by a start address, an inner (X) element count, a signed inner step, an outer (Y) row count, a signed outer step and a 16-bit configuration word. Each accepted transfer strobe presents the current address and moves the generator on. Within a row the address grows by the X step. On the last element of a row it grows by the Y step instead, so one generator can cover interleaved, strided and windowed two-dimensional patterns. Data movement, bus arbitration and peripheral handshakes belong to the surrounding logic.

A channel can start in two ways. The direct start takes the parameters from the configuration inputs. The descriptor start reads them as consecutive 16-bit words over a small read port with one cycle of latency. When a buffer completes, the configuration word decides what happens next. The channel can halt, restart the same buffer (autobuffer), follow a pointer stored in the descriptor (linked list), or step to the next descriptor in a packed array. Array descriptors carry only the low half of the start address, and the high half is the page captured at launch. Row-end and buffer-end interrupt pulses are produced under separate enables.

Top module: `dma_agen`

## Requirements
- R1: After reset `running`, `fetching`, `irq_row`, `irq_done` and `dm_rd` are all low.
- R2: A `go_reg` pulse while the channel is idle loads the direct parameters. From the next cycle `running` is high and `addr` equals the start address. The configuration word fields are: bit 0 selects 2D, bits 2:1 select completion (0 stop, 1 autobuffer, 2 linked list, 3 array), bit 3 enables the row interrupt, and bit 4 enables the buffer interrupt.
- R3: While running, each cycle with `xfer` high advances `addr` by the sign-extended X step. A cycle with `xfer` low leaves `addr` unchanged.
- R4: In 2D mode the last element of each row advances `addr` by the sign-extended Y step and reloads the X count. The buffer ends after Y rows. In 1D mode it ends after X elements.
- R5: A count of zero means 65536.
- R6: `irq_done` pulses for one cycle, in the cycle after the final transfer of a buffer, when bit 4 is set. In stop mode the channel is idle in that same cycle.
- R7: In autobuffer mode the channel stays running after the final transfer, and `addr` returns to the start address.
- R8: In 2D mode with bit 3 set, `irq_row` pulses for one cycle after the last transfer of every row.
- R9: A linked descriptor is nine consecutive words starting at the pointer, in this order: next pointer low, next pointer high, start low, start high, configuration, X count, X step, Y count, Y step. It is read with `dm_rd` only while `fetching` is high, and the channel then runs with the loaded values.
- R10: An array descriptor is six consecutive words, in this order: start low, configuration, X count, X step, Y count, Y step. The start high half comes from the page captured at launch from `cfg_start[31:16]`, and the next descriptor follows at pointer + 6.
- R11: `go_reg` and `go_desc` are ignored while running or fetching. `xfer` is ignored while not running. The channel is never running and fetching at once.
- R12: In linked-list or array mode, the cycle after a buffer's final transfer shows `fetching` high, with the fetch reading from the next descriptor pointer. A `go_reg` start takes its first descriptor pointer from `go_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_reg | input | 1 | Start from the direct parameter inputs |
| go_desc | input | 1 | Start by fetching a descriptor at `go_ptr` |
| go_ptr | input | AW | First descriptor word address |
| go_linked | input | 1 | Descriptor start format: 1 linked, 0 array |
| cfg_start | input | AW | Direct start address; its high half is the array page |
| cfg_word | input | 16 | Direct configuration word |
| cfg_xcnt | input | 16 | Direct X count |
| cfg_xmod | input | 16 | Direct signed X step |
| cfg_ycnt | input | 16 | Direct Y count |
| cfg_ymod | input | 16 | Direct signed Y step |
| xfer | input | 1 | Transfer accepted this cycle |
| addr | output | AW | Current transfer address |
| running | output | 1 | Channel is generating addresses |
| fetching | output | 1 | Channel is reading a descriptor |
| irq_row | output | 1 | Row-complete pulse |
| irq_done | output | 1 | Buffer-complete pulse |
| dm_rd | output | 1 | Descriptor word read strobe |
| dm_addr | output | AW | Descriptor word address |
| dm_rdata | input | 16 | Descriptor word, valid the cycle after `dm_rd` |

## Verification
The bench builds the block with its default 32-bit address. At that width the split of a start address into low and high descriptor words, and the page-relative arrays, are exercised for real. Sign extension of negative steps into the upper half is also observable. The default also lets the zero-count case run its full 65536 transfers, and lets linked pointers refer to descriptors anywhere in the word space the bench memory decodes.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;

  localparam int WORD_W      = 16;
  localparam int LINK_WORDS  = 9;
  localparam int ARRAY_WORDS = 6;

  typedef enum logic [1:0] {
    FLOW_STOP  = 2'd0,
    FLOW_AUTO  = 2'd1,
    FLOW_LINK  = 2'd2,
    FLOW_ARRAY = 2'd3
  } flow_e;

  typedef struct packed {
    logic [10:0] spare;
    logic        done_ie;
    logic        row_ie;
    flow_e       flow;
    logic        two_d;
  } chan_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FETCH = 2'd2
  } chan_st_e;

  typedef enum logic [3:0] {
    F_NEXT_LO, F_NEXT_HI, F_START_LO, F_START_HI, F_CFG,
    F_XCNT, F_XMOD, F_YCNT, F_YMOD, F_NONE
  } dfield_e;

  // Number of words in a descriptor of the given format.
  function automatic logic [3:0] desc_len(input logic linked);
    return linked ? 4'(LINK_WORDS) : 4'(ARRAY_WORDS);
  endfunction

  // Which parameter the word at a given offset carries.
  function automatic dfield_e field_at(input logic linked, input logic [3:0] idx);
    dfield_e f;
    f = F_NONE;
    if (linked) begin
      case (idx)
        4'd0: f = F_NEXT_LO;
        4'd1: f = F_NEXT_HI;
        4'd2: f = F_START_LO;
        4'd3: f = F_START_HI;
        4'd4: f = F_CFG;
        4'd5: f = F_XCNT;
        4'd6: f = F_XMOD;
        4'd7: f = F_YCNT;
        4'd8: f = F_YMOD;
        default: f = F_NONE;
      endcase
    end else begin
      case (idx)
        4'd0: f = F_START_LO;
        4'd1: f = F_CFG;
        4'd2: f = F_XCNT;
        4'd3: f = F_XMOD;
        4'd4: f = F_YCNT;
        4'd5: f = F_YMOD;
        default: f = F_NONE;
      endcase
    end
    return f;
  endfunction

endpackage

// File: rtl/dma_agen_walk.sv
// Address walker: inner/outer counters and signed address stepping.
module dma_agen_walk
  import dma_agen_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [AW-1:0]     ld_start,
  input  logic [WORD_W-1:0] ld_xcnt,
  input  logic [WORD_W-1:0] ld_xmod,
  input  logic [WORD_W-1:0] ld_ycnt,
  input  logic [WORD_W-1:0] ld_ymod,
  input  logic              ld_two_d,
  input  logic              step,
  output logic [AW-1:0]     addr,
  output logic              row_end,
  output logic              buf_end
);

  localparam int SW = WORD_W + 1;

  // Element span of a count field; zero stands for the full range.
  function automatic logic [SW-1:0] span(input logic [WORD_W-1:0] c);
    return (c == '0) ? {1'b1, {WORD_W{1'b0}}} : {1'b0, c};
  endfunction

  // Address plus a sign-extended step.
  function automatic logic [AW-1:0] adv(input logic [AW-1:0] a, input logic [WORD_W-1:0] m);
    logic [AW-1:0] ext;
    ext = {{(AW-WORD_W){m[WORD_W-1]}}, m};
    return a + ext;
  endfunction

  logic [AW-1:0]     base_q, addr_q;
  logic [WORD_W-1:0] xcnt_q, xmod_q, ycnt_q, ymod_q;
  logic              two_d_q;
  logic [SW-1:0]     xrem_q, yrem_q;

  assign row_end = (xrem_q == SW'(1));
  assign buf_end = row_end && (!two_d_q || (yrem_q == SW'(1)));
  assign addr    = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      addr_q  <= '0;
      xcnt_q  <= '0;
      xmod_q  <= '0;
      ycnt_q  <= '0;
      ymod_q  <= '0;
      two_d_q <= 1'b0;
      xrem_q  <= '0;
      yrem_q  <= '0;
    end else if (load) begin
      base_q  <= ld_start;
      addr_q  <= ld_start;
      xcnt_q  <= ld_xcnt;
      xmod_q  <= ld_xmod;
      ycnt_q  <= ld_ycnt;
      ymod_q  <= ld_ymod;
      two_d_q <= ld_two_d;
      xrem_q  <= span(ld_xcnt);
      yrem_q  <= span(ld_ycnt);
    end else if (step) begin
      if (buf_end) begin
        addr_q <= base_q;
        xrem_q <= span(xcnt_q);
        yrem_q <= span(ycnt_q);
      end else if (row_end) begin
        addr_q <= adv(addr_q, ymod_q);
        xrem_q <= span(xcnt_q);
        yrem_q <= yrem_q - SW'(1);
      end else begin
        addr_q <= adv(addr_q, xmod_q);
        xrem_q <= xrem_q - SW'(1);
      end
    end
  end

endmodule

// File: rtl/dma_agen_fetch.sv
// Descriptor reader: one word per cycle, data returns a cycle later.
module dma_agen_fetch
  import dma_agen_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 begin_i,
  input  logic [AW-1:0]        ptr_i,
  input  logic                 linked_i,
  input  logic [AW-WORD_W-1:0] page_i,
  output logic                 dm_rd,
  output logic [AW-1:0]        dm_addr,
  input  logic [WORD_W-1:0]    dm_rdata,
  output logic                 busy,
  output logic                 done,
  output logic [AW-1:0]        f_start,
  output logic [WORD_W-1:0]    f_cfg,
  output logic [WORD_W-1:0]    f_xcnt,
  output logic [WORD_W-1:0]    f_xmod,
  output logic [WORD_W-1:0]    f_ycnt,
  output logic [WORD_W-1:0]    f_ymod,
  output logic [AW-1:0]        f_next
);

  localparam int HW = AW - WORD_W;

  logic              busy_q, linked_q, cap_v_q, done_q;
  logic [AW-1:0]     ptr_q;
  logic [3:0]        iss_q, cap_idx_q, len;
  logic [WORD_W-1:0] nlo_q, slo_q, cfg_q, xc_q, xm_q, yc_q, ym_q;
  logic [HW-1:0]     nhi_q, shi_q;

  assign len     = desc_len(linked_q);
  assign dm_rd   = busy_q && (iss_q < len);
  assign dm_addr = ptr_q + AW'(iss_q);
  assign busy    = busy_q;
  assign done    = done_q;
  assign f_start = {shi_q, slo_q};
  assign f_cfg   = cfg_q;
  assign f_xcnt  = xc_q;
  assign f_xmod  = xm_q;
  assign f_ycnt  = yc_q;
  assign f_ymod  = ym_q;
  assign f_next  = linked_q ? {nhi_q, nlo_q} : ptr_q + AW'(len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      linked_q  <= 1'b0;
      cap_v_q   <= 1'b0;
      done_q    <= 1'b0;
      ptr_q     <= '0;
      iss_q     <= '0;
      cap_idx_q <= '0;
      nlo_q     <= '0;
      nhi_q     <= '0;
      slo_q     <= '0;
      shi_q     <= '0;
      cfg_q     <= '0;
      xc_q      <= '0;
      xm_q      <= '0;
      yc_q      <= '0;
      ym_q      <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (begin_i) begin
          busy_q   <= 1'b1;
          ptr_q    <= ptr_i;
          linked_q <= linked_i;
          iss_q    <= '0;
          cap_v_q  <= 1'b0;
          shi_q    <= page_i;
        end
      end else begin
        if (dm_rd) iss_q <= iss_q + 4'd1;
        cap_v_q   <= dm_rd;
        cap_idx_q <= iss_q;
        if (cap_v_q) begin
          case (field_at(linked_q, cap_idx_q))
            F_NEXT_LO:  nlo_q <= dm_rdata;
            F_NEXT_HI:  nhi_q <= dm_rdata[HW-1:0];
            F_START_LO: slo_q <= dm_rdata;
            F_START_HI: shi_q <= dm_rdata[HW-1:0];
            F_CFG:      cfg_q <= dm_rdata;
            F_XCNT:     xc_q  <= dm_rdata;
            F_XMOD:     xm_q  <= dm_rdata;
            F_YCNT:     yc_q  <= dm_rdata;
            F_YMOD:     ym_q  <= dm_rdata;
            default: ;
          endcase
          if (cap_idx_q == len - 4'd1) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/dma_agen.sv
// Channel controller: start commands, completion flow and interrupts.
module dma_agen
  import dma_agen_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_reg,
  input  logic              go_desc,
  input  logic [AW-1:0]     go_ptr,
  input  logic              go_linked,
  input  logic [AW-1:0]     cfg_start,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic [WORD_W-1:0] cfg_xcnt,
  input  logic [WORD_W-1:0] cfg_xmod,
  input  logic [WORD_W-1:0] cfg_ycnt,
  input  logic [WORD_W-1:0] cfg_ymod,
  input  logic              xfer,
  output logic [AW-1:0]     addr,
  output logic              running,
  output logic              fetching,
  output logic              irq_row,
  output logic              irq_done,
  output logic              dm_rd,
  output logic [AW-1:0]     dm_addr,
  input  logic [WORD_W-1:0] dm_rdata
);

  localparam int HW = AW - WORD_W;

  chan_st_e  st_q, st_d;
  chan_cfg_t cfg_q;
  logic [AW-1:0] next_q;
  logic [HW-1:0] page_q;
  logic          irq_row_q, irq_done_q;

  // Named internal events used by the checker.
  logic ev_step, ev_row_end, ev_buf_end, ev_chain;
  logic take_reg, take_desc;
  logic row_end, buf_end;

  // Fetch interface
  logic              f_begin, f_linked, f_busy, f_done;
  logic [AW-1:0]     f_ptr, f_start, f_next;
  logic [HW-1:0]     f_page;
  logic [WORD_W-1:0] f_cfg, f_xcnt, f_xmod, f_ycnt, f_ymod;

  // Walker load mux
  logic              w_load, w_two_d;
  logic [AW-1:0]     w_start;
  logic [WORD_W-1:0] w_xcnt, w_xmod, w_ycnt, w_ymod;

  assign running  = (st_q == ST_RUN);
  assign fetching = (st_q == ST_FETCH);

  assign take_reg   = (st_q == ST_IDLE) && go_reg;
  assign take_desc  = (st_q == ST_IDLE) && go_desc && !go_reg;
  assign ev_step    = running && xfer;
  assign ev_row_end = ev_step && row_end;
  assign ev_buf_end = ev_step && buf_end;
  assign ev_chain   = ev_buf_end && ((cfg_q.flow == FLOW_LINK) || (cfg_q.flow == FLOW_ARRAY));

  assign f_begin  = take_desc || ev_chain;
  assign f_ptr    = take_desc ? go_ptr : next_q;
  assign f_linked = take_desc ? go_linked : (cfg_q.flow == FLOW_LINK);
  assign f_page   = take_desc ? cfg_start[AW-1:WORD_W] : page_q;

  assign w_load  = take_reg || f_done;
  assign w_start = take_reg ? cfg_start : f_start;
  assign w_xcnt  = take_reg ? cfg_xcnt  : f_xcnt;
  assign w_xmod  = take_reg ? cfg_xmod  : f_xmod;
  assign w_ycnt  = take_reg ? cfg_ycnt  : f_ycnt;
  assign w_ymod  = take_reg ? cfg_ymod  : f_ymod;
  assign w_two_d = take_reg ? cfg_word[0] : f_cfg[0];

  assign irq_row  = irq_row_q;
  assign irq_done = irq_done_q;

  dma_agen_walk #(.AW(AW)) walk_u (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (w_load),
    .ld_start (w_start),
    .ld_xcnt  (w_xcnt),
    .ld_xmod  (w_xmod),
    .ld_ycnt  (w_ycnt),
    .ld_ymod  (w_ymod),
    .ld_two_d (w_two_d),
    .step     (ev_step),
    .addr     (addr),
    .row_end  (row_end),
    .buf_end  (buf_end)
  );

  dma_agen_fetch #(.AW(AW)) fetch_u (
    .clk      (clk),
    .rst_n    (rst_n),
    .begin_i  (f_begin),
    .ptr_i    (f_ptr),
    .linked_i (f_linked),
    .page_i   (f_page),
    .dm_rd    (dm_rd),
    .dm_addr  (dm_addr),
    .dm_rdata (dm_rdata),
    .busy     (f_busy),
    .done     (f_done),
    .f_start  (f_start),
    .f_cfg    (f_cfg),
    .f_xcnt   (f_xcnt),
    .f_xmod   (f_xmod),
    .f_ycnt   (f_ycnt),
    .f_ymod   (f_ymod),
    .f_next   (f_next)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (take_reg)       st_d = ST_RUN;
        else if (take_desc) st_d = ST_FETCH;
      end
      ST_RUN: begin
        if (ev_buf_end) begin
          case (cfg_q.flow)
            FLOW_STOP: st_d = ST_IDLE;
            FLOW_AUTO: st_d = ST_RUN;
            default:   st_d = ST_FETCH;
          endcase
        end
      end
      ST_FETCH: begin
        if (f_done) st_d = ST_RUN;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cfg_q      <= '0;
      next_q     <= '0;
      page_q     <= '0;
      irq_row_q  <= 1'b0;
      irq_done_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      irq_row_q  <= ev_row_end && cfg_q.two_d && cfg_q.row_ie;
      irq_done_q <= ev_buf_end && cfg_q.done_ie;
      if (take_reg) begin
        cfg_q  <= chan_cfg_t'(cfg_word);
        next_q <= go_ptr;
        page_q <= cfg_start[AW-1:WORD_W];
      end else if (take_desc) begin
        page_q <= cfg_start[AW-1:WORD_W];
      end else if (f_done) begin
        cfg_q  <= chan_cfg_t'(f_cfg);
        next_q <= f_next;
      end
    end
  end

endmodule

// File: rtl/dma_agen_chk.sv
module dma_agen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          running,
  input logic          fetching,
  input logic          xfer,
  input logic [AW-1:0] addr,
  input logic          dm_rd,
  input logic          irq_row,
  input logic          irq_done,
  input logic          ev_row_end,
  input logic          ev_buf_end,
  input logic [1:0]    flow
);

  assert_one_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(running && fetching));

  assert_rd_in_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dm_rd |-> fetching);

  assert_hold_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !xfer) |=> (running && $stable(addr)));

  assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> $past(ev_buf_end));

  assert_row_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_row |-> $past(ev_row_end));

  assert_stop_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_buf_end && flow == 2'd0) |=> (!running && !fetching));

  assert_auto_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_buf_end && flow == 2'd1) |=> running);

  assert_chain_fetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_buf_end && flow[1]) |=> fetching);

endmodule

bind dma_agen dma_agen_chk #(.AW(AW)) chk_u (
  .clk        (clk),
  .rst_n      (rst_n),
  .running    (running),
  .fetching   (fetching),
  .xfer       (xfer),
  .addr       (addr),
  .dm_rd      (dm_rd),
  .irq_row    (irq_row),
  .irq_done   (irq_done),
  .ev_row_end (ev_row_end),
  .ev_buf_end (ev_buf_end),
  .flow       (cfg_q.flow)
);

// File: tb/dma_agen_test.sv
module dma_agen_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          go_reg = 1'b0, go_desc = 1'b0, go_linked = 1'b0, xfer = 1'b0;
  logic [AW-1:0] go_ptr = '0, cfg_start = '0;
  logic [15:0]   cfg_word = '0, cfg_xcnt = '0, cfg_xmod = '0, cfg_ycnt = '0, cfg_ymod = '0;
  logic [AW-1:0] addr, dm_addr;
  logic          running, fetching, irq_row, irq_done, dm_rd;
  logic [15:0]   dm_rdata = '0;

  logic [15:0]   mem [0:255];
  int            rd_log [0:63];
  int            rd_n = 0;
  int            nchk = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_agen #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .go_reg(go_reg), .go_desc(go_desc), .go_ptr(go_ptr),
    .go_linked(go_linked), .cfg_start(cfg_start), .cfg_word(cfg_word),
    .cfg_xcnt(cfg_xcnt), .cfg_xmod(cfg_xmod), .cfg_ycnt(cfg_ycnt), .cfg_ymod(cfg_ymod),
    .xfer(xfer), .addr(addr), .running(running), .fetching(fetching),
    .irq_row(irq_row), .irq_done(irq_done), .dm_rd(dm_rd), .dm_addr(dm_addr),
    .dm_rdata(dm_rdata)
  );

  // Descriptor memory model with one cycle read latency, plus read log.
  always @(posedge clk) begin
    if (dm_rd) begin
      dm_rdata <= mem[dm_addr[7:0]];
      if (rd_n < 64) rd_log[rd_n] <= int'(dm_addr);
      rd_n <= rd_n + 1;
    end
  end

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic int span(input logic [15:0] c);
    return (c == 16'd0) ? 65536 : int'(c);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; xfer = 1'b0; go_reg = 1'b0; go_desc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic start_reg(input logic [31:0] st, input logic [15:0] cw, input logic [15:0] xc,
                           input logic [15:0] xm, input logic [15:0] yc, input logic [15:0] ym);
    @(negedge clk);
    cfg_start = st; cfg_word = cw; cfg_xcnt = xc; cfg_xmod = xm; cfg_ycnt = yc; cfg_ymod = ym;
    go_reg = 1'b1;
    @(negedge clk);
    go_reg = 1'b0;
    chk(running == 1'b1, "R2 running after go_reg", running, 1);
    chk(addr == st, "R2 first address", addr, st);
  endtask

  // Walk one whole buffer against a bench model of the address sequence.
  task automatic run_buf(input logic [31:0] st, input logic [15:0] cw, input logic [15:0] xc,
                         input logic [15:0] xm, input logic [15:0] yc, input logic [15:0] ym,
                         input bit gaps, input string tag);
    logic [31:0] m;
    int xn, yn, xi, yi;
    bit fin, er, ed, x, rl, bl, two_d;
    two_d = cw[0];
    xn = span(xc);
    yn = two_d ? span(yc) : 1;
    m = st; xi = 0; yi = 0; fin = 0; er = 0; ed = 0;
    while (!fin) begin
      @(negedge clk);
      chk(irq_row == er, {tag, " R8 row irq"}, irq_row, er);
      chk(irq_done == ed, {tag, " R6 done irq"}, irq_done, ed);
      x = gaps ? (($urandom % 3) != 0) : 1'b1;
      xfer = x; er = 0; ed = 0;
      if (x) begin
        chk(running == 1'b1, {tag, " R2 running"}, running, 1);
        chk(addr == m, {tag, " R3/R4 address"}, addr, m);
        rl = (xi == xn - 1);
        bl = rl && (!two_d || yi == yn - 1);
        er = rl && two_d && cw[3];
        ed = bl && cw[4];
        if (bl) fin = 1;
        else if (rl) begin m = m + sx(ym); xi = 0; yi++; end
        else begin m = m + sx(xm); xi++; end
      end
    end
    @(negedge clk);
    xfer = 1'b0;
    chk(irq_row == er, {tag, " R8 last row irq"}, irq_row, er);
    chk(irq_done == ed, {tag, " R6 final done irq"}, irq_done, ed);
  endtask

  task automatic wait_run(input string tag);
    int n;
    n = 0;
    while (!running && n < 60) begin @(negedge clk); n++; end
    chk(running == 1'b1, {tag, " running after fetch"}, running, 1);
  endtask

  task automatic chk_reads(input int base, input int ptr, input int n, input string tag);
    chk(rd_n - base == n, {tag, " word count"}, rd_n - base, n);
    for (int i = 0; i < n; i++)
      chk(rd_log[base + i] == ptr + i, {tag, " word address"}, rd_log[base + i], ptr + i);
  endtask

  task automatic put(input int a, input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2,
                     input logic [15:0] w3, input logic [15:0] w4, input logic [15:0] w5);
    mem[a] = w0; mem[a+1] = w1; mem[a+2] = w2; mem[a+3] = w3; mem[a+4] = w4; mem[a+5] = w5;
  endtask

  initial begin
    int base;
    logic [15:0] xc, yc, xm, ym, cw;
    logic [31:0] st;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    void'($urandom(32'd7311));
    do_reset();

    // R1: reset state
    chk(running == 0, "R1 running", running, 0);
    chk(fetching == 0, "R1 fetching", fetching, 0);
    chk(irq_row == 0 && irq_done == 0, "R1 irqs", {irq_row, irq_done}, 0);
    chk(dm_rd == 0, "R1 dm_rd", dm_rd, 0);

    // R11: xfer while idle does nothing
    @(negedge clk); xfer = 1'b1;
    repeat (3) @(negedge clk);
    xfer = 1'b0;
    chk(running == 0 && fetching == 0, "R11 xfer idle ignored", running, 0);

    // 1D stop, positive step, buffer interrupt (R2 R3 R6)
    start_reg(32'h1000_0000, 16'h0010, 16'd5, 16'd4, 16'd0, 16'd0);
    run_buf(32'h1000_0000, 16'h0010, 16'd5, 16'd4, 16'd0, 16'd0, 1'b0, "1d stop");
    chk(running == 0, "R6 stop halts", running, 0);

    // 1D negative step with gaps (R3)
    start_reg(32'h0000_0010, 16'h0010, 16'd7, 16'hFFFC, 16'd0, 16'd0);
    run_buf(32'h0000_0010, 16'h0010, 16'd7, 16'hFFFC, 16'd0, 16'd0, 1'b1, "1d negative");
    chk(running == 0, "R6 stop halts neg", running, 0);

    // 2D stop with row interrupts (R4 R8)
    start_reg(32'h2000_0100, 16'h0019, 16'd4, 16'd2, 16'd3, 16'hFFF0);
    run_buf(32'h2000_0100, 16'h0019, 16'd4, 16'd2, 16'd3, 16'hFFF0, 1'b1, "2d stop");
    chk(running == 0, "R6 stop halts 2d", running, 0);

    // Random 2D and 1D buffers in stop mode (R3 R4 R6 R8)
    for (int k = 0; k < 8; k++) begin
      xc = 16'(1 + $urandom % 6); yc = 16'(1 + $urandom % 5);
      xm = 16'($urandom); ym = 16'($urandom);
      cw = 16'({$urandom % 2, $urandom % 2, 2'b00, $urandom % 2});
      st = $urandom;
      start_reg(st, cw, xc, xm, yc, ym);
      run_buf(st, cw, xc, xm, yc, ym, 1'b1, "random");
      chk(running == 0, "R6 random stop halts", running, 0);
    end

    // Autobuffer 2D (R7) and ignored commands while running (R11)
    start_reg(32'h3000_0000, 16'h001B, 16'd3, 16'd4, 16'd2, 16'hFFF8);
    run_buf(32'h3000_0000, 16'h001B, 16'd3, 16'd4, 16'd2, 16'hFFF8, 1'b1, "auto pass1");
    chk(running == 1, "R7 still running", running, 1);
    chk(addr == 32'h3000_0000, "R7 wrapped to start", addr, 32'h3000_0000);
    @(negedge clk);
    cfg_start = 32'h7777_0000; cfg_xcnt = 16'd9; go_reg = 1'b1; go_desc = 1'b1;
    @(negedge clk);
    go_reg = 1'b0; go_desc = 1'b0;
    chk(running == 1 && fetching == 0, "R11 go ignored while running", fetching, 0);
    chk(addr == 32'h3000_0000, "R11 address kept", addr, 32'h3000_0000);
    run_buf(32'h3000_0000, 16'h001B, 16'd3, 16'd4, 16'd2, 16'hFFF8, 1'b1, "auto pass2");
    chk(running == 1, "R7 running after pass2", running, 1);
    do_reset();

    // Count of zero means 65536 (R5)
    start_reg(32'h4000_0000, 16'h0010, 16'd0, 16'd1, 16'd0, 16'd0);
    run_buf(32'h4000_0000, 16'h0010, 16'd0, 16'd1, 16'd0, 16'd0, 1'b0, "R5 zero count");
    chk(running == 0, "R5 halts after 65536", running, 0);

    // Array descriptors (R10 R12); second one stops
    put(8'h40, 16'h0100, 16'h0017, 16'd3, 16'd1, 16'd2, 16'd5);
    put(8'h46, 16'h0200, 16'h0010, 16'd4, 16'd2, 16'd0, 16'd0);
    base = rd_n;
    @(negedge clk);
    go_ptr = 32'h40; go_linked = 1'b0; cfg_start = 32'hABCD_0000; go_desc = 1'b1;
    @(negedge clk);
    go_desc = 1'b0;
    chk(fetching == 1, "R10 fetching", fetching, 1);
    wait_run("R10 array first");
    chk_reads(base, 32'h40, 6, "R10 array first");
    chk(addr == 32'hABCD_0100, "R10 paged start", addr, 32'hABCD_0100);
    run_buf(32'hABCD_0100, 16'h0017, 16'd3, 16'd1, 16'd2, 16'd5, 1'b1, "array d0");
    chk(fetching == 1, "R12 array chains", fetching, 1);
    base = rd_n;
    wait_run("R12 array second");
    chk_reads(base, 32'h46, 6, "R10 array next at ptr+6");
    run_buf(32'hABCD_0200, 16'h0010, 16'd4, 16'd2, 16'd0, 16'd0, 1'b0, "array d1");
    chk(running == 0 && fetching == 0, "R6 array stop", running, 0);

    // Linked descriptors (R9 R12)
    put(8'h80, 16'h0010, 16'h0000, 16'h5000, 16'h0002, 16'h0014, 16'd3);
    mem[8'h86] = 16'hFFFF; mem[8'h87] = 16'd0; mem[8'h88] = 16'd0;
    put(8'h10, 16'h0000, 16'h0000, 16'h6000, 16'h0003, 16'h0019, 16'd2);
    mem[8'h16] = 16'd4; mem[8'h17] = 16'd2; mem[8'h18] = 16'h0008;
    base = rd_n;
    @(negedge clk);
    go_ptr = 32'h80; go_linked = 1'b1; go_desc = 1'b1;
    @(negedge clk);
    go_desc = 1'b0;
    wait_run("R9 linked first");
    chk_reads(base, 32'h80, 9, "R9 linked first");
    run_buf(32'h0002_5000, 16'h0014, 16'd3, 16'hFFFF, 16'd0, 16'd0, 1'b1, "R9 linked d0");
    chk(fetching == 1, "R12 linked chains", fetching, 1);
    base = rd_n;
    wait_run("R12 linked second");
    chk_reads(base, 32'h10, 9, "R12 linked next pointer");
    run_buf(32'h0003_6000, 16'h0019, 16'd2, 16'd4, 16'd2, 16'h0008, 1'b1, "R9 linked d1");
    chk(running == 0 && fetching == 0, "R6 linked stop", running, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule